// File: doc/BRIEF.md
# Register Window Control Unit

This block tracks which register window of a circular window file is active, and decides whether a procedure-entry or procedure-exit operation may proceed. It keeps the window pointer, a count of windows free for entry (`save_avail`), a count of windows that can be exited (`rest_avail`), a count of windows already cleaned (`clean_cnt`), a count of windows that belong to another address space (`alt_cnt`), and a 6-bit window-state word (`win_state`). The window-state word holds two 3-bit trap-type fields.

A pipeline front end presents one request per cycle. The request is either an entry (SAVE), an exit (RESTORE) or an exit that jumps to an address (RETURN). In the next cycle the unit either commits the pointer and counter update or reports exactly one trap, together with its kind and a 3-bit type. When a trap is reported, no state changes. A privileged write port loads any of the state registers directly, for test setup and for trap handlers. The register file and the trap vector logic are outside this block.

Top module: `regwin_ctl`

## Requirements
- R1: After reset, `win_ptr` is 0, `save_avail` is NWIN-2, `rest_avail` is 0, `clean_cnt` is NWIN-1, `alt_cnt` is 0, `win_state` is 0 and `trap_valid` is 0.
- R2: SAVE (`req_op`=0) with `save_avail`=0 raises a spill trap. If `alt_cnt` is nonzero, the kind is 2 (spill-other) and the type is `win_state[5:3]`. Otherwise the kind is 1 (spill-normal) and the type is `win_state[2:0]`.
- R3: SAVE with `save_avail`≠0 and `clean_cnt` equal to `rest_avail` raises kind 5 (clean-window) with type 0.
- R4: A SAVE that raises no trap moves `win_ptr` to (`win_ptr`+1) mod NWIN, decrements `save_avail` and increments `rest_avail`.
- R5: RESTORE (`req_op`=1) with `rest_avail`=0 raises a fill trap. If `alt_cnt` is nonzero, the kind is 4 (fill-other) and the type is `win_state[5:3]`. Otherwise the kind is 3 (fill-normal) and the type is `win_state[2:0]`.
- R6: A RESTORE that raises no trap moves `win_ptr` to (`win_ptr`+NWIN-1) mod NWIN, increments `save_avail` and decrements `rest_avail`.
- R7: RETURN (`req_op`=2) with `rest_avail`=0 raises the fill trap of R5, even when the target address is misaligned.
- R8: RETURN with `rest_avail`≠0 and `ret_addr[1:0]`≠0 raises kind 6 (alignment) with type 0.
- R9: A RETURN that raises no trap updates the pointer and counters as in R6.
- R10: When a trap is raised, `win_ptr`, the four counters and `win_state` keep their values.
- R11: A write with `wr_en`=1 loads `wr_data` into the register picked by `wr_sel`: 0 pointer, 1 `save_avail`, 2 `rest_avail`, 3 `clean_cnt`, 4 `alt_cnt`, 5 `win_state`. A request in the same cycle is ignored and raises no trap.
- R12: Trap outputs are registered and appear one cycle after the request, for that single cycle. With no trap, `trap_valid` is 0 and `trap_kind` is 0. `req_op`=3 is no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 SAVE, 1 RESTORE, 2 RETURN, 3 none |
| ret_addr | input | ADDR_W | Jump target for RETURN |
| wr_en | input | 1 | Privileged register write |
| wr_sel | input | 3 | Register picked by the write |
| wr_data | input | WD_W | Write value, low bits used |
| trap_valid | output | 1 | A trap was raised by the previous request |
| trap_kind | output | 3 | Trap kind code (R2, R3, R5, R8) |
| trap_type | output | 3 | Trap type field |
| win_ptr | output | PTR_W | Current window pointer |
| save_avail | output | PTR_W | Windows free for SAVE |
| rest_avail | output | PTR_W | Windows available to RESTORE |
| clean_cnt | output | PTR_W | Clean window count |
| alt_cnt | output | PTR_W | Other-space window count |
| win_state | output | 6 | Window-state word holding two type fields |

## Verification
The bench builds the unit with NWIN=5. Five is not a power of two, so the explicit wrap logic of the pointer is selected and the pointer wraps in both directions, 4→0 and 0→4. Every start pointer is combined with each counter in 0..2, both `alt_cnt` cases, every operation and every low-address pattern. This reaches every trap priority, every type-field selection and every equal/unequal clean-window case.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int WSTATE_W = 6;
   localparam int TTYPE_W  = 3;

   typedef enum logic [1:0] {
      OP_SAVE    = 2'd0,
      OP_RESTORE = 2'd1,
      OP_RETURN  = 2'd2,
      OP_IDLE    = 2'd3
   } win_op_e;

   typedef enum logic [2:0] {
      TK_NONE      = 3'd0,
      TK_SPILL_NRM = 3'd1,
      TK_SPILL_OTH = 3'd2,
      TK_FILL_NRM  = 3'd3,
      TK_FILL_OTH  = 3'd4,
      TK_CLEAN     = 3'd5,
      TK_ALIGN     = 3'd6
   } trap_kind_e;

   typedef enum logic [2:0] {
      WS_PTR     = 3'd0,
      WS_SAVE    = 3'd1,
      WS_REST    = 3'd2,
      WS_CLEAN   = 3'd3,
      WS_ALT     = 3'd4,
      WS_WSTATE  = 3'd5
   } wr_sel_e;

   typedef struct packed {
      logic               hit;
      trap_kind_e         kind;
      logic [TTYPE_W-1:0] ttype;
   } trap_t;

endpackage

// File: rtl/regwin_ptr_step.sv
module regwin_ptr_step #(
   parameter int NWIN  = 8,
   parameter int PTR_W = 3
) (
   input  logic [PTR_W-1:0] cur,
   output logic [PTR_W-1:0] nxt_up,
   output logic [PTR_W-1:0] nxt_dn
);
   localparam bit             IS_POW2 = (NWIN == (1 << PTR_W));
   localparam logic [PTR_W-1:0] LAST  = PTR_W'(NWIN - 1);

   generate
      if (IS_POW2) begin : g_pow2
         // natural wrap of a full-width counter
         assign nxt_up = cur + 1'b1;
         assign nxt_dn = cur - 1'b1;
      end else begin : g_mod
         assign nxt_up = (cur == LAST) ? '0 : cur + 1'b1;
         assign nxt_dn = (cur == '0) ? LAST : cur - 1'b1;
      end
   endgenerate
endmodule

// File: rtl/regwin_trap_eval.sv
module regwin_trap_eval
   import regwin_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic                req_go,
   input  win_op_e             op,
   input  logic [CNT_W-1:0]    save_avail,
   input  logic [CNT_W-1:0]    rest_avail,
   input  logic [CNT_W-1:0]    clean_cnt,
   input  logic [CNT_W-1:0]    alt_cnt,
   input  logic [WSTATE_W-1:0] win_state,
   input  logic [1:0]          addr_lo,
   output trap_t               trap,
   output logic                do_save,
   output logic                do_restore
);
   logic               use_alt;
   logic [TTYPE_W-1:0] sel_tt;

   assign use_alt = |alt_cnt;
   assign sel_tt  = use_alt ? win_state[5:3] : win_state[2:0];

   // Spill/fill is checked first; clean-window and alignment only after.
   always_comb begin
      trap       = '{hit: 1'b0, kind: TK_NONE, ttype: '0};
      do_save    = 1'b0;
      do_restore = 1'b0;
      if (req_go) begin
         case (op)
            OP_SAVE: begin
               if (save_avail == '0) begin
                  trap.hit   = 1'b1;
                  trap.kind  = use_alt ? TK_SPILL_OTH : TK_SPILL_NRM;
                  trap.ttype = sel_tt;
               end else if (clean_cnt == rest_avail) begin
                  trap.hit   = 1'b1;
                  trap.kind  = TK_CLEAN;
               end else begin
                  do_save = 1'b1;
               end
            end
            OP_RESTORE, OP_RETURN: begin
               if (rest_avail == '0) begin
                  trap.hit   = 1'b1;
                  trap.kind  = use_alt ? TK_FILL_OTH : TK_FILL_NRM;
                  trap.ttype = sel_tt;
               end else if (op == OP_RETURN && addr_lo != 2'b00) begin
                  trap.hit   = 1'b1;
                  trap.kind  = TK_ALIGN;
               end else begin
                  do_restore = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/regwin_state.sv
module regwin_state
   import regwin_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int PTR_W = 3,
   parameter int WD_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [WD_W-1:0]     wr_data,
   input  logic                do_save,
   input  logic                do_restore,
   input  logic [PTR_W-1:0]    ptr_up,
   input  logic [PTR_W-1:0]    ptr_dn,
   output logic [PTR_W-1:0]    ptr_q,
   output logic [PTR_W-1:0]    save_q,
   output logic [PTR_W-1:0]    rest_q,
   output logic [PTR_W-1:0]    clean_q,
   output logic [PTR_W-1:0]    alt_q,
   output logic [WSTATE_W-1:0] wstate_q
);
   localparam logic [PTR_W-1:0] ONE        = PTR_W'(1);
   localparam logic [PTR_W-1:0] SAVE_RST   = PTR_W'(NWIN - 2);
   localparam logic [PTR_W-1:0] CLEAN_RST  = PTR_W'(NWIN - 1);

   logic [PTR_W-1:0] wr_cnt;
   logic             unused_wr_hi;

   assign wr_cnt       = wr_data[PTR_W-1:0];
   assign unused_wr_hi = ^wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         save_q   <= SAVE_RST;
         rest_q   <= '0;
         clean_q  <= CLEAN_RST;
         alt_q    <= '0;
         wstate_q <= '0;
      end else if (wr_en) begin
         case (wr_sel_e'(wr_sel))
            WS_PTR:    ptr_q    <= wr_cnt;
            WS_SAVE:   save_q   <= wr_cnt;
            WS_REST:   rest_q   <= wr_cnt;
            WS_CLEAN:  clean_q  <= wr_cnt;
            WS_ALT:    alt_q    <= wr_cnt;
            WS_WSTATE: wstate_q <= wr_data[WSTATE_W-1:0];
            default: ;
         endcase
      end else if (do_save) begin
         ptr_q  <= ptr_up;
         save_q <= save_q - ONE;
         rest_q <= rest_q + ONE;
      end else if (do_restore) begin
         ptr_q  <= ptr_dn;
         save_q <= save_q + ONE;
         rest_q <= rest_q - ONE;
      end
   end

   // R4
   save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_save |=> (save_q == $past(save_q) - ONE) && (rest_q == $past(rest_q) + ONE));

   // R6
   restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_restore |=> (save_q == $past(save_q) + ONE) && (rest_q == $past(rest_q) - ONE));

   // R11
   exclusive_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !(do_save || do_restore));
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
   import regwin_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int ADDR_W = 32,
   parameter int WD_W   = 8,
   localparam int PTR_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          req_op,
   input  logic [ADDR_W-1:0]   ret_addr,
   input  logic                wr_en,
   input  logic [2:0]          wr_sel,
   input  logic [WD_W-1:0]     wr_data,
   output logic                trap_valid,
   output logic [2:0]          trap_kind,
   output logic [2:0]          trap_type,
   output logic [PTR_W-1:0]    win_ptr,
   output logic [PTR_W-1:0]    save_avail,
   output logic [PTR_W-1:0]    rest_avail,
   output logic [PTR_W-1:0]    clean_cnt,
   output logic [PTR_W-1:0]    alt_cnt,
   output logic [5:0]          win_state
);
   generate
      if (NWIN < 3) begin : g_bad_nwin
         $error("regwin_ctl: NWIN must be at least 3");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("regwin_ctl: ADDR_W must be at least 2");
      end
      if (WD_W < WSTATE_W || WD_W < PTR_W) begin : g_bad_wd
         $error("regwin_ctl: WD_W too narrow for the state registers");
      end
   endgenerate

   logic             req_go;
   logic             do_save, do_restore;
   logic [PTR_W-1:0] ptr_up, ptr_dn;
   trap_t            trap_n, trap_q;
   logic             unused_addr;

   assign req_go      = req_valid && !wr_en;
   assign unused_addr = ^ret_addr;

   regwin_ptr_step #(.NWIN(NWIN), .PTR_W(PTR_W)) u_step (
      .cur    (win_ptr),
      .nxt_up (ptr_up),
      .nxt_dn (ptr_dn)
   );

   regwin_trap_eval #(.CNT_W(PTR_W)) u_eval (
      .req_go     (req_go),
      .op         (win_op_e'(req_op)),
      .save_avail (save_avail),
      .rest_avail (rest_avail),
      .clean_cnt  (clean_cnt),
      .alt_cnt    (alt_cnt),
      .win_state  (win_state),
      .addr_lo    (ret_addr[1:0]),
      .trap       (trap_n),
      .do_save    (do_save),
      .do_restore (do_restore)
   );

   regwin_state #(.NWIN(NWIN), .PTR_W(PTR_W), .WD_W(WD_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .do_save    (do_save),
      .do_restore (do_restore),
      .ptr_up     (ptr_up),
      .ptr_dn     (ptr_dn),
      .ptr_q      (win_ptr),
      .save_q     (save_avail),
      .rest_q     (rest_avail),
      .clean_q    (clean_cnt),
      .alt_q      (alt_cnt),
      .wstate_q   (win_state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) trap_q <= '{hit: 1'b0, kind: TK_NONE, ttype: '0};
      else        trap_q <= trap_n;
   end

   assign trap_valid = trap_q.hit;
   assign trap_kind  = trap_q.kind;
   assign trap_type  = trap_q.ttype;

   // R10
   trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |-> ($stable(win_ptr) && $stable(save_avail) && $stable(rest_avail)
                      && $stable(clean_cnt) && $stable(win_state)));

   // R12
   kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid == (trap_kind != 3'd0)));

   // R7
   fill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_go && req_op == 2'd2 && rest_avail == '0)
      |=> (trap_kind == 3'd3 || trap_kind == 3'd4));

   // R2
   spill_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_go && req_op == 2'd0 && save_avail != '0)
      |=> (trap_kind != 3'd1 && trap_kind != 3'd2));

   // R11
   write_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !trap_valid);
endmodule

// File: tb/regwin_ctl_test.sv
`timescale 1ns/1ps
module regwin_ctl_test;
   localparam int NW = 5;
   localparam int PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd3;
   logic [31:0]   ret_addr = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_sel = '0;
   logic [7:0]    wr_data = '0;
   logic          trap_valid;
   logic [2:0]    trap_kind, trap_type;
   logic [PW-1:0] win_ptr, save_avail, rest_avail, clean_cnt, alt_cnt;
   logic [5:0]    win_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   regwin_ctl #(.NWIN(NW), .ADDR_W(32), .WD_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .ret_addr(ret_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_type(trap_type),
      .win_ptr(win_ptr), .save_avail(save_avail), .rest_avail(rest_avail),
      .clean_cnt(clean_cnt), .alt_cnt(alt_cnt), .win_state(win_state)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] state_word();
      return {14'd0, win_ptr, save_avail, rest_avail, clean_cnt, alt_cnt, win_state};
   endfunction

   function automatic logic [31:0] pack_state(int p, int s, int r, int c, int a, int w);
      return {14'd0, PW'(p), PW'(s), PW'(r), PW'(c), PW'(a), 6'(w)};
   endfunction

   task automatic wr(input int sel, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(val);
   endtask

   task automatic wr_end();
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic request(input int op, input logic [31:0] addr);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); ret_addr = addr;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'd3;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1 state", state_word(), pack_state(0, NW-2, 0, NW-1, 0, 0));
      check("R1 trap", {29'd0, trap_valid, trap_kind == 3'd0, 1'b0}, {29'd0, 1'b0, 1'b1, 1'b0});

      // R12 no-op code raises nothing and changes nothing
      request(3, 32'h3);
      check("R12 idle op", {trap_valid, trap_kind, state_word()[28:0]},
            {1'b0, 3'd0, pack_state(0, NW-2, 0, NW-1, 0, 0)[28:0]});

      // R11 write port loads every register
      wr(0, 4); wr(1, 2); wr(2, 1); wr(3, 3); wr(4, 1); wr(5, 8'h2d); wr_end();
      check("R11 load", state_word(), pack_state(4, 2, 1, 3, 1, 8'h2d));

      // R11 request during a write is ignored
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'd0;
      req_valid = 1'b1; req_op = 2'd0;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0; req_op = 2'd3;
      check("R11 blocked trap", {31'd0, trap_valid}, 32'd0);
      check("R11 blocked state", state_word(), pack_state(4, 0, 1, 3, 1, 8'h2d));

      // Sweep: all ops, pointers, counters 0..2, alt 0/1, address low bits
      for (int op = 0; op < 3; op++)
      for (int p = 0; p < NW; p++)
      for (int cs = 0; cs < 3; cs++)
      for (int cr = 0; cr < 3; cr++)
      for (int cw = 0; cw < 3; cw++)
      for (int ow = 0; ow < 2; ow++)
      for (int lo = 0; lo < ((op == 2) ? 4 : 1); lo++) begin
         int ws, ek, et, np, ns, nr;
         bit hit;
         string tag, stag;
         ws = (p * 13 + cs * 5 + ow * 3 + cw * 17 + 7) % 64;
         wr(0, p); wr(1, cs); wr(2, cr); wr(3, cw); wr(4, ow); wr(5, ws); wr_end();
         hit = 1'b0; ek = 0; et = 0; np = p; ns = cs; nr = cr;
         if (op == 0) begin
            if (cs == 0) begin
               hit = 1; ek = ow ? 2 : 1; et = ow ? (ws >> 3) : (ws & 7); tag = "R2";
            end else if (cw == cr) begin
               hit = 1; ek = 5; tag = "R3";
            end else begin
               np = (p + 1) % NW; ns = cs - 1; nr = cr + 1; tag = "R4";
            end
         end else begin
            if (cr == 0) begin
               hit = 1; ek = ow ? 4 : 3; et = ow ? (ws >> 3) : (ws & 7);
               tag = (op == 2) ? "R7" : "R5";
            end else if (op == 2 && lo != 0) begin
               hit = 1; ek = 6; tag = "R8";
            end else begin
               np = (p + NW - 1) % NW; ns = cs + 1; nr = cr - 1;
               tag = (op == 2) ? "R9" : "R6";
            end
         end
         request(op, {28'h1234567, 2'b00, 2'(lo)});
         check({tag, " trap"}, {25'd0, trap_valid, trap_kind, trap_type},
               {25'd0, hit, 3'(ek), 3'(et)});
         stag = hit ? "R10" : tag;
         check({stag, " state"}, state_word(), pack_state(np, ns, nr, cw, ow, ws));
         @(negedge clk);
         // R12 trap pulse lasts one cycle
         check("R12 pulse", {28'd0, trap_valid, trap_kind}, 32'd0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule